// File: doc/BRIEF.md
# FPGA configuration load sequencer

This block brings up a downstream programmable device through its three handshake pins: an active-low program request, a bidirectional init line and a done line. Software starts a load by pulsing `start_i` with the image length in bytes. The block then runs a fixed sequence with no software involvement. It optionally raises an enable line and lets go of the init line. It holds the program request low for a set number of cycles, then waits for the target to report that its memory is clear. Next it moves every image byte from a valid/ready stream onto a byte-wide write port. Last, it waits for the target to report that configuration is complete.

Each of the two waits has its own cycle limit and its own failure code. The enable line is dropped on every way out of the sequence. Software sees `busy_o` while a load runs, then a one-cycle `finished_o` pulse. At that pulse `result_o` carries the 2-bit outcome. If no configuration space is present for the target, the block ends at once and leaves every pin as it was.

Top module: `fpga_cfg_loader`

## Requirements
- R1: If `cfg_present_i` is 0 when start is accepted, `finished_o` pulses on the next cycle with `result_o` = 1 (no space). `busy_o` stays low, `enable_o` stays low, `prog_n_o` stays high and `init_oe_o` keeps its value.
- R2: If `enable_req_i` is 1 at start, `enable_o` is high from the first busy cycle to the end of the load. On every exit (codes 0, 2 and 3) `enable_o` is low when `finished_o` pulses. If `enable_req_i` is 0, `enable_o` never rises.
- R3: `init_oe_o` is 1 out of reset, which holds the init line low. The block clears it one cycle before `prog_n_o` falls, and it stays 0 for the whole time the program request is low.
- R4: `prog_n_o` is low for exactly `PROG_CYCLES` consecutive cycles per load, and high at all other times.
- R5: If the synchronized init input stays low for `INIT_TIMEOUT` cycles after the program request returns high, the load ends with `result_o` = 2. In that case `busy_o` is high for exactly 1 + `PROG_CYCLES` + `INIT_TIMEOUT` cycles.
- R6: After init reads high, exactly `byte_count` bytes are taken from the stream. Each byte goes to `wr_data_o` in arrival order, with `wr_strobe_o` high for one cycle on the cycle after its transfer. A count of zero takes no bytes.
- R7: If the synchronized done input stays low for `DONE_TIMEOUT` cycles after the last byte, the load ends with `result_o` = 3.
- R8: When done reads high within its limit, the load ends with `result_o` = 0.
- R9: `finished_o` is high for exactly one cycle per load. `start_i` has no effect while `busy_o` is high: the byte count and target settings of a running load do not change.
- R10: `init_i` and `done_i` pass through two flip-flops before the sequencer uses them. `s_ready_o` first goes high on the third cycle after `init_i` rises, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| byte_count_i | input | CNT_W | Image length in bytes, latched at start |
| cfg_present_i | input | 1 | Target has a configuration space |
| enable_req_i | input | 1 | Target needs its enable line driven |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_ready_o | output | 1 | Stream byte accepted this cycle when valid |
| wr_data_o | output | 8 | Byte presented to the target data port |
| wr_strobe_o | output | 1 | One-cycle write strobe for `wr_data_o` |
| prog_n_o | output | 1 | Active-low program request to the target |
| init_oe_o | output | 1 | 1 = drive the init line low, 0 = release it |
| init_i | input | 1 | Init line level read back from the pad |
| done_i | input | 1 | Done line from the target |
| enable_o | output | 1 | Target enable |
| busy_o | output | 1 | Load in progress |
| finished_o | output | 1 | One-cycle pulse when `result_o` is valid |
| result_o | output | 2 | 0 ok, 1 no space, 2 init timeout, 3 done timeout |

## Verification
The case hardest to reach from the ports is a start request arriving while a load is midway through streaming. It must change neither the byte count nor the outcome. The bench makes this happen by pulsing start with a different count and with no configuration space between two stream bytes, then counting the strobes and the finished pulses. The two timeout paths need the target to stay silent for exact cycle counts. The bench therefore uses small limits and checks the busy length, not only the result code. The synchronizer delay is measured by raising init on a known falling clock edge and watching which cycle ready rises in.

// File: rtl/fcl_pkg.sv
// Package: shared state encoding and result codes for the configuration
// load sequencer. Assumes a single clock domain for all users.
package fcl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_PROG,
        ST_WAIT_INIT,
        ST_STREAM,
        ST_WAIT_DONE
    } fcl_state_e;

    localparam logic [1:0] RES_OK     = 2'd0;
    localparam logic [1:0] RES_NOCFG  = 2'd1;
    localparam logic [1:0] RES_NOINIT = 2'd2;
    localparam logic [1:0] RES_NODONE = 2'd3;

    // Largest of three limits, used to size the shared cycle counter
    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/fcl_sync.sv
// Module: fcl_sync
// Two-flop synchronizer for a vector of independent single-bit inputs.
// Assumes each bit is a slow level signal; no bus coherency is implied.
module fcl_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic meta_q;
            logic stab_q;

            // Two-stage capture of one asynchronous bit
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    stab_q <= 1'b0;
                end else begin
                    meta_q <= async_i[b];
                    stab_q <= meta_q;
                end
            end

            assign sync_o[b] = stab_q;
        end
    endgenerate

endmodule

// File: rtl/fcl_timer.sv
// Module: fcl_timer
// Free-running cycle counter with synchronous clear, shared by the
// program pulse and both waits. Assumes the width covers every limit.
module fcl_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);

    // Clear on request, otherwise count up one per cycle
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_o <= '0;
        end else begin
            cnt_o <= cnt_o + W'(1);
        end
    end

endmodule

// File: rtl/fcl_byte_port.sv
// Module: fcl_byte_port
// Turns one accepted stream transfer into a registered byte with a
// one-cycle write strobe. Assumes at most one transfer per cycle.
module fcl_byte_port #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_i,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] wr_data_o,
    output logic          wr_strobe_o
);

    // Register the byte and raise the strobe for exactly one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_data_o   <= '0;
            wr_strobe_o <= 1'b0;
        end else begin
            wr_strobe_o <= take_i;
            if (take_i) begin
                wr_data_o <= data_i;
            end
        end
    end

endmodule

// File: rtl/fpga_cfg_loader.sv
// Module: fpga_cfg_loader
// Sequences a full configuration load of a downstream device: optional
// enable, init release, timed program pulse, init wait with limit, byte
// streaming, done wait with limit. Exactly one result per accepted start.
// Assumes init_i and done_i are asynchronous and the init pad is driven
// low whenever init_oe_o is 1.
module fpga_cfg_loader
    import fcl_pkg::*;
#(
    parameter int CNT_W        = 24,
    parameter int PROG_CYCLES  = 20,
    parameter int INIT_TIMEOUT = 10000000,
    parameter int DONE_TIMEOUT = 100000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] byte_count_i,
    input  logic             cfg_present_i,
    input  logic             enable_req_i,
    input  logic             s_valid_i,
    input  logic [7:0]       s_data_i,
    output logic             s_ready_o,
    output logic [7:0]       wr_data_o,
    output logic             wr_strobe_o,
    output logic             prog_n_o,
    output logic             init_oe_o,
    input  logic             init_i,
    input  logic             done_i,
    output logic             enable_o,
    output logic             busy_o,
    output logic             finished_o,
    output logic [1:0]       result_o
);

    localparam int unsigned MAX_LIM = max3(PROG_CYCLES, INIT_TIMEOUT, DONE_TIMEOUT);
    localparam int TMR_W = $clog2(MAX_LIM + 1);
    localparam logic [TMR_W-1:0] PROG_LAST = TMR_W'(PROG_CYCLES - 1);
    localparam logic [TMR_W-1:0] INIT_LAST = TMR_W'(INIT_TIMEOUT - 1);
    localparam logic [TMR_W-1:0] DONE_LAST = TMR_W'(DONE_TIMEOUT - 1);

    fcl_state_e       state_q, state_d;
    logic [CNT_W-1:0] remain_q;
    logic [TMR_W-1:0] tmr_cnt;
    logic             tmr_clr;
    logic [1:0]       pins_sync;
    logic             init_s, done_s;
    logic             take;
    logic             exit_now;
    logic [1:0]       exit_code;
    logic             go;

    fcl_sync #(.WIDTH(2)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({done_i, init_i}),
        .sync_o  (pins_sync)
    );

    assign init_s = pins_sync[0];
    assign done_s = pins_sync[1];

    fcl_timer #(.W(TMR_W)) tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (tmr_clr),
        .cnt_o (tmr_cnt)
    );

    fcl_byte_port #(.DW(8)) port_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_i      (take),
        .data_i      (s_data_i),
        .wr_data_o   (wr_data_o),
        .wr_strobe_o (wr_strobe_o)
    );

    assign s_ready_o = (state_q == ST_STREAM) && (remain_q != '0);
    assign take      = s_valid_i && s_ready_o;
    assign go        = (state_q == ST_IDLE) && start_i && cfg_present_i;

    // Next-state selection, timer clear and exit code for each stage
    always_comb begin
        state_d   = state_q;
        exit_now  = 1'b0;
        exit_code = RES_OK;
        unique case (state_q)
            ST_IDLE: begin
                if (go) state_d = ST_ARM;
            end
            ST_ARM: begin
                state_d = ST_PROG;
            end
            ST_PROG: begin
                if (tmr_cnt == PROG_LAST) state_d = ST_WAIT_INIT;
            end
            ST_WAIT_INIT: begin
                if (init_s) begin
                    state_d = ST_STREAM;
                end else if (tmr_cnt == INIT_LAST) begin
                    state_d   = ST_IDLE;
                    exit_now  = 1'b1;
                    exit_code = RES_NOINIT;
                end
            end
            ST_STREAM: begin
                if (remain_q == '0) state_d = ST_WAIT_DONE;
            end
            ST_WAIT_DONE: begin
                if (done_s) begin
                    state_d   = ST_IDLE;
                    exit_now  = 1'b1;
                    exit_code = RES_OK;
                end else if (tmr_cnt == DONE_LAST) begin
                    state_d   = ST_IDLE;
                    exit_now  = 1'b1;
                    exit_code = RES_NODONE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
        tmr_clr = (state_d != state_q);
    end

    // Sequencer state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Remaining byte count: loaded at start, reduced per transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (go) begin
            remain_q <= byte_count_i;
        end else if (take) begin
            remain_q <= remain_q - CNT_W'(1);
        end
    end

    // Target pin drive: enable, init release and program request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_o  <= 1'b0;
            init_oe_o <= 1'b1;
            prog_n_o  <= 1'b1;
        end else begin
            if (go) begin
                enable_o  <= enable_req_i;
                init_oe_o <= 1'b0;
            end else if (exit_now) begin
                enable_o <= 1'b0;
            end
            if (state_q == ST_ARM) begin
                prog_n_o <= 1'b0;
            end else if (state_q == ST_PROG && state_d != ST_PROG) begin
                prog_n_o <= 1'b1;
            end
        end
    end

    // Status toward software: busy window, finish pulse, result code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o     <= 1'b0;
            finished_o <= 1'b0;
            result_o   <= RES_OK;
        end else begin
            finished_o <= 1'b0;
            if (go) begin
                busy_o <= 1'b1;
            end else if (state_q == ST_IDLE && start_i) begin
                finished_o <= 1'b1;
                result_o   <= RES_NOCFG;
            end else if (exit_now) begin
                busy_o     <= 1'b0;
                finished_o <= 1'b1;
                result_o   <= exit_code;
            end
        end
    end

endmodule

// File: rtl/fcl_checker.sv
// Module: fcl_checker
// Temporal properties of the load sequencer, observed at its ports.
// Attached to every fpga_cfg_loader instance by the bind below.
module fcl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       s_valid_i,
    input logic       s_ready_o,
    input logic       wr_strobe_o,
    input logic       prog_n_o,
    input logic       init_oe_o,
    input logic       enable_o,
    input logic       busy_o,
    input logic       finished_o,
    input logic [1:0] result_o
);

    assert_release_before_prog_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n_o |-> !init_oe_o);

    assert_prog_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> prog_n_o);

    assert_enable_off_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !enable_o);

    assert_ready_only_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> busy_o);

    assert_strobe_follows_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe_o |-> $past(s_valid_i && s_ready_o));

    assert_finish_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        finished_o |=> !finished_o);

    assert_busy_ends_with_finish_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || finished_o));

    assert_nocfg_pins_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (finished_o && result_o == 2'd1) |-> (prog_n_o && !enable_o && !busy_o));

endmodule

bind fpga_cfg_loader fcl_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .s_valid_i   (s_valid_i),
    .s_ready_o   (s_ready_o),
    .wr_strobe_o (wr_strobe_o),
    .prog_n_o    (prog_n_o),
    .init_oe_o   (init_oe_o),
    .enable_o    (enable_o),
    .busy_o      (busy_o),
    .finished_o  (finished_o),
    .result_o    (result_o)
);

// File: tb/fpga_cfg_loader_tb_top.sv
// Directed bench for fpga_cfg_loader: one task per scenario, each task
// checks its own results against values derived from the requirements.
module fpga_cfg_loader_tb_top;

    localparam int CNT_W   = 8;
    localparam int PROG    = 20;
    localparam int INIT_TO = 50;
    localparam int DONE_TO = 60;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [CNT_W-1:0] byte_count_i = '0;
    logic             cfg_present_i = 1'b0;
    logic             enable_req_i = 1'b0;
    logic             s_valid_i = 1'b0;
    logic [7:0]       s_data_i = '0;
    logic             s_ready_o;
    logic [7:0]       wr_data_o;
    logic             wr_strobe_o;
    logic             prog_n_o;
    logic             init_oe_o;
    logic             init_i = 1'b0;
    logic             done_i = 1'b0;
    logic             enable_o;
    logic             busy_o;
    logic             finished_o;
    logic [1:0]       result_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Monitor state, sampled on falling edges
    int       m_prog_low;
    int       m_bad_oe;
    int       m_busy;
    int       m_fin;
    int       m_en_seen;
    int       m_ncap;
    logic [7:0] m_cap [0:15];

    always #4 clk = ~clk;

    fpga_cfg_loader #(
        .CNT_W(CNT_W), .PROG_CYCLES(PROG),
        .INIT_TIMEOUT(INIT_TO), .DONE_TIMEOUT(DONE_TO)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_count_i(byte_count_i),
        .cfg_present_i(cfg_present_i), .enable_req_i(enable_req_i),
        .s_valid_i(s_valid_i), .s_data_i(s_data_i), .s_ready_o(s_ready_o),
        .wr_data_o(wr_data_o), .wr_strobe_o(wr_strobe_o), .prog_n_o(prog_n_o),
        .init_oe_o(init_oe_o), .init_i(init_i), .done_i(done_i),
        .enable_o(enable_o), .busy_o(busy_o), .finished_o(finished_o),
        .result_o(result_o)
    );

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (!prog_n_o) m_prog_low <= m_prog_low + 1;
        if (!prog_n_o && init_oe_o) m_bad_oe <= m_bad_oe + 1;
        if (busy_o) m_busy <= m_busy + 1;
        if (finished_o) m_fin <= m_fin + 1;
        if (enable_o) m_en_seen <= 1;
        if (wr_strobe_o && m_ncap < 16) begin
            m_cap[m_ncap] <= wr_data_o;
            m_ncap <= m_ncap + 1;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(posedge clk);
        #1;
        m_prog_low = 0; m_bad_oe = 0; m_busy = 0; m_fin = 0;
        m_en_seen = 0; m_ncap = 0;
    endtask

    task automatic pulse_start(logic cfg, logic en, int n);
        @(negedge clk);
        cfg_present_i = cfg; enable_req_i = en;
        byte_count_i = CNT_W'(n); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_finish();
        int k = 0;
        while (!finished_o && k < 3000) begin
            @(negedge clk);
            k++;
        end
        chk("R9 finish seen", int'(finished_o), 1);
    endtask

    task automatic wait_prog_rise();
        int k = 0;
        while (!(prog_n_o && m_prog_low > 0) && k < 500) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic send_byte(logic [7:0] b);
        logic rdy;
        int k = 0;
        @(negedge clk);
        s_valid_i = 1'b1; s_data_i = b;
        rdy = s_ready_o;
        while (!rdy && k < 500) begin
            @(negedge clk);
            rdy = s_ready_o;
            k++;
        end
        @(negedge clk);
        s_valid_i = 1'b0;
    endtask

    task automatic settle();
        init_i = 1'b0; done_i = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R3 reset init_oe", int'(init_oe_o), 1);
        chk("R4 reset prog_n", int'(prog_n_o), 1);
        chk("R2 reset enable", int'(enable_o), 0);
        chk("R9 reset busy", int'(busy_o), 0);
        chk("R9 reset finished", int'(finished_o), 0);
        chk("R6 reset ready", int'(s_ready_o), 0);
    endtask

    task automatic t_nocfg();
        clear_mon();
        pulse_start(1'b0, 1'b1, 4);
        chk("R1 finished pulse", int'(finished_o), 1);
        chk("R1 result no space", int'(result_o), 1);
        @(negedge clk);
        chk("R1 busy never", m_busy, 0);
        chk("R1 enable untouched", m_en_seen, 0);
        chk("R1 prog untouched", m_prog_low, 0);
        chk("R1 init_oe kept", int'(init_oe_o), 1);
        chk("R9 single finish", m_fin, 1);
    endtask

    task automatic t_load(logic en, int n, int seed, logic poke);
        clear_mon();
        pulse_start(1'b1, en, n);
        wait_prog_rise();
        chk("R4 program low cycles", m_prog_low, PROG);
        chk("R3 init released during program", m_bad_oe, 0);
        chk("R3 init_oe off", int'(init_oe_o), 0);
        chk("R2 enable during load", int'(enable_o), int'(en));
        init_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R10 ready held by sync", int'(s_ready_o), 0);
        @(negedge clk);
        chk("R10 ready after sync", int'(s_ready_o), n > 0 ? 1 : 0);
        for (int i = 0; i < n; i++) begin
            send_byte(8'((seed + i * 37) & 8'hff));
            if (poke && i == 1) begin
                start_i = 1'b1; byte_count_i = CNT_W'(2); cfg_present_i = 1'b0;
                @(negedge clk);
                start_i = 1'b0;
                @(negedge clk);
            end
        end
        repeat (3) @(negedge clk);
        done_i = 1'b1;
        wait_finish();
        chk("R8 result ok", int'(result_o), 0);
        chk("R2 enable dropped on success", int'(enable_o), 0);
        @(negedge clk);
        chk("R9 one finish per load", m_fin, 1);
        chk("R6 byte count", m_ncap, n);
        for (int i = 0; i < n && i < 16; i++) begin
            chk("R6 byte order", int'(m_cap[i]), (seed + i * 37) & 255);
        end
        if (!en) chk("R2 enable never with flag clear", m_en_seen, 0);
        settle();
    endtask

    task automatic t_init_timeout();
        clear_mon();
        pulse_start(1'b1, 1'b1, 3);
        wait_finish();
        chk("R5 result init timeout", int'(result_o), 2);
        chk("R2 enable dropped on init fail", int'(enable_o), 0);
        chk("R5 busy length", m_busy, 1 + PROG + INIT_TO);
        chk("R6 no bytes on init fail", m_ncap, 0);
        settle();
    endtask

    task automatic t_done_timeout();
        clear_mon();
        pulse_start(1'b1, 1'b1, 2);
        wait_prog_rise();
        init_i = 1'b1;
        send_byte(8'hA5);
        send_byte(8'h3C);
        wait_finish();
        chk("R7 result done timeout", int'(result_o), 3);
        chk("R2 enable dropped on done fail", int'(enable_o), 0);
        chk("R7 bytes before timeout", m_ncap, 2);
        settle();
    endtask

    initial begin
        m_prog_low = 0; m_bad_oe = 0; m_busy = 0; m_fin = 0;
        m_en_seen = 0; m_ncap = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_nocfg();
        t_load(1'b1, 5, 17, 1'b0);
        t_load(1'b0, 3, 200, 1'b0);
        t_load(1'b1, 0, 0, 1'b0);
        t_load(1'b1, 6, 9, 1'b1);
        t_init_timeout();
        t_done_timeout();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=0", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule